// File: doc/BRIEF.md
# Trace Buffer Write Address Controller

This block takes a stream of 32-bit trace words and writes them, one word per clock, into a window of memory. Software sets the window with a start address and an end address. The write pointer moves up by 4 bytes after each word. When the pointer reaches the end address, software's choice of mode decides what happens next. In circular mode the pointer returns to the start address. In stop-at-end mode capture halts and the block reports that the buffer is full. A small FIFO sits between the producer and the memory port. It absorbs short bursts and holds words while capture is paused.

Control and status are plain pins that a register shell can map directly:
- Window bounds and the mode bit.
- Single-cycle start, stop and rewind pulses.
- Interrupt enable and write-1-to-clear lines.
- The live write pointer, the FIFO-empty flag, the full status and the raw interrupt bits.

The trace input is valid/ready. `in_ready` is low only when the FIFO holds `DEPTH` words. The producer is not required to hold a word while `in_ready` is low. A word offered in that state is discarded, and the discard is reported as an overflow. The memory side is a write-only port with address, data and a write strobe. It has no back-pressure, so each strobe is a completed write.

Top module: `trace_wr_ctrl`

## Requirements
- R1: After reset, `cur_addr` is 0, `fifo_empty` is 1, `in_ready` is 1, `mem_we` is 0, `full_active` is 0, `irq_raw` is 00 and `irq` is 0.
- R2: While capture is on, the FIFO is not empty and the pointer has not halted, the block makes one memory write per cycle. Each write goes to the address in `cur_addr` and carries the oldest word in the FIFO, so words come out in arrival order. After a write that is not at the end address, `cur_addr` rises by 4.
- R3: A `rewind` pulse loads `cur_addr` from `cfg_start` at the next edge. It also releases a halted pointer.
- R4: With `cfg_loop` = 1, a write at `cfg_end` is followed by `cur_addr` = `cfg_start`. If start equals end, every write goes to that one address.
- R5: With `cfg_loop` = 0, a write at `cfg_end` leaves `cur_addr` at `cfg_end` and raises `full_active`. No further write happens until a rewind. Words that arrive in the meantime stay in the FIFO.
- R6: A `trig_on` pulse starts capture and a `trig_off` pulse stops it. When both arrive in the same cycle, stop wins. While capture is stopped, no memory write occurs and words accumulate in the FIFO.
- R7: `fifo_empty` is 1 exactly when the FIFO holds no word. `in_ready` is 0 exactly when it holds `DEPTH` words (default 4).
- R8: A word offered with `in_ready` = 0 is dropped and is never written to memory. It also sets `irq_raw` bit 0, the overflow bit.
- R9: Every memory write at `cfg_end` sets `irq_raw` bit 1, the memory-full bit, in either mode.
- R10: `irq` is the OR over both bits of `irq_raw & irq_en`. Writing 1 on an `irq_clr` bit clears that raw bit, but a set in the same cycle wins. Raw bits hold until cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_start | input | 32 | First address of the window |
| cfg_end | input | 32 | Last address of the window |
| cfg_loop | input | 1 | 1: circular, 0: stop at end |
| trig_on | input | 1 | Pulse: start capture |
| trig_off | input | 1 | Pulse: stop capture |
| rewind | input | 1 | Pulse: pointer back to start |
| irq_en | input | 2 | Interrupt enables, bit 0 overflow, bit 1 memory full |
| irq_clr | input | 2 | Write-1-to-clear for the raw bits |
| in_valid | input | 1 | Trace word offered |
| in_data | input | 32 | Trace word |
| in_ready | output | 1 | FIFO has room |
| mem_addr | output | 32 | Memory write address |
| mem_wdata | output | 32 | Memory write data |
| mem_we | output | 1 | Memory write strobe |
| cur_addr | output | 32 | Address of the next write |
| fifo_empty | output | 1 | FIFO holds no word |
| full_active | output | 1 | Halted at end in stop mode |
| irq_raw | output | 2 | Raw interrupt bits |
| irq | output | 1 | Combined interrupt |

## Verification
The bench checks every write strobe's address and data against a separate pointer model and an ordered record of the accepted words. It runs this check over several windows:
- A circular window run for more than one lap, which shows that the wrap goes back to the start and not past the end.
- A short run that never reaches the end, which shows the memory-full bit stays quiet.
- A single-address window, which exercises the case where start equals end.
- A stop-at-end window fed more words than it has room for, which separates halting from wrapping and shows the extra words are held rather than lost.

A burst of five words with capture off separates back-pressure from data loss. Exactly four of those words must later reach memory. Pausing, resuming and rewinding in the middle of a run show that the pointer and the FIFO respond only to their own pulses.

// File: rtl/trace_wr_pkg.sv
package trace_wr_pkg;
  localparam int IRQ_N    = 2;
  localparam int IRQ_OVF  = 0;  // bit 0: FIFO overflow
  localparam int IRQ_FULL = 1;  // bit 1: write landed on end address
  typedef logic [IRQ_N-1:0] irq_vec_t;
endpackage

// File: rtl/trace_fifo.sv
module trace_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          empty,
  output logic          full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] store [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  function automatic logic [PW-1:0] step_ptr(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= step_ptr(wp);
      if (pop)  rp <= step_ptr(rp);
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push) store[wp] <= wdata;
  end

  assign rdata = store[rp];
  assign empty = (cnt == '0);
  assign full  = (cnt == CW'(DEPTH));

  // R2: the drain side never pops a word that is not there
  p_pop_has_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty) else $error("pop from empty FIFO");
  // R7: a push is only accepted while there is room
  p_push_has_room_r7: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full) else $error("push into full FIFO");
  // R7: a full FIFO stays full until something is popped
  p_full_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop) |=> full) else $error("full flag dropped without pop");
endmodule

// File: rtl/trace_addr_gen.sv
module trace_addr_gen #(
  parameter int AW   = 32,
  parameter int STEP = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire,
  input  logic          rewind,
  input  logic          loop_en,
  input  logic [AW-1:0] start_a,
  input  logic [AW-1:0] end_a,
  output logic [AW-1:0] cur,
  output logic          at_end,
  output logic          halted
);
  assign at_end = (cur == end_a);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur    <= '0;
      halted <= 1'b0;
    end else if (rewind) begin
      cur    <= start_a;
      halted <= 1'b0;
    end else if (fire) begin
      if (at_end) begin
        if (loop_en) cur <= start_a;
        else         halted <= 1'b1;
      end else begin
        cur <= cur + AW'(STEP);
      end
    end
  end

  // R3: rewind loads the start address
  p_rewind_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rewind |=> (cur == $past(start_a))) else $error("rewind missed");
  // R2: a write away from the end moves the pointer by one step
  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !rewind && !at_end) |=> (cur == $past(cur) + AW'(STEP)))
    else $error("bad pointer step");
  // R5: a halted pointer stays put until rewound
  p_halt_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !rewind) |=> (halted && $stable(cur))) else $error("halted pointer moved");
  // R5: no write is issued while halted
  p_no_fire_halted_r5: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !fire) else $error("write while halted");
endmodule

// File: rtl/trace_irq.sv
module trace_irq
  import trace_wr_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  irq_vec_t set,
  input  irq_vec_t clr,
  input  irq_vec_t en,
  output irq_vec_t raw,
  output logic     irq
);
  for (genvar i = 0; i < IRQ_N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      raw[i] <= 1'b0;
      else if (set[i]) raw[i] <= 1'b1;
      else if (clr[i]) raw[i] <= 1'b0;
    end

    // R10: raw bits are sticky until cleared
    p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (raw[i] && !clr[i]) |=> raw[i]) else $error("raw bit lost");
    // R10: a clear without a concurrent set takes effect
    p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[i] && !set[i]) |=> !raw[i]) else $error("clear ignored");
  end

  assign irq = |(raw & en);
endmodule

// File: rtl/trace_wr_ctrl.sv
module trace_wr_ctrl
  import trace_wr_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int DEPTH = 4,
  parameter int STEP  = DW / 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] cfg_start,
  input  logic [AW-1:0] cfg_end,
  input  logic          cfg_loop,
  input  logic          trig_on,
  input  logic          trig_off,
  input  logic          rewind,
  input  logic [1:0]    irq_en,
  input  logic [1:0]    irq_clr,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          in_ready,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we,
  output logic [AW-1:0] cur_addr,
  output logic          fifo_empty,
  output logic          full_active,
  output logic [1:0]    irq_raw,
  output logic          irq
);
  logic     active, f_full, push, fire, at_end, halted;
  irq_vec_t set_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        active <= 1'b0;
    else if (trig_off) active <= 1'b0;
    else if (trig_on)  active <= 1'b1;
  end

  assign push     = in_valid && !f_full;
  assign in_ready = !f_full;
  assign fire     = active && !fifo_empty && !halted;

  trace_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(fire),
    .wdata(in_data), .rdata(mem_wdata), .empty(fifo_empty), .full(f_full)
  );

  trace_addr_gen #(.AW(AW), .STEP(STEP)) u_addr (
    .clk(clk), .rst_n(rst_n), .fire(fire), .rewind(rewind), .loop_en(cfg_loop),
    .start_a(cfg_start), .end_a(cfg_end), .cur(cur_addr), .at_end(at_end),
    .halted(halted)
  );

  always_comb begin
    set_v           = '0;
    set_v[IRQ_OVF]  = in_valid && f_full;
    set_v[IRQ_FULL] = fire && at_end;
  end

  trace_irq u_irq (
    .clk(clk), .rst_n(rst_n), .set(set_v), .clr(irq_clr), .en(irq_en),
    .raw(irq_raw), .irq(irq)
  );

  assign mem_we      = fire;
  assign mem_addr    = cur_addr;
  assign full_active = halted;

  // R6: a stop pulse silences the write port from the next cycle
  p_off_stops_r6: assert property (@(posedge clk) disable iff (!rst_n)
    trig_off |=> !mem_we) else $error("write after stop");
  // R8: an offered word while full raises the overflow bit
  p_ovf_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |=> irq_raw[IRQ_OVF]) else $error("overflow not flagged");
  // R9: a write on the end address raises the memory-full bit
  p_full_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && (mem_addr == cfg_end)) |=> irq_raw[IRQ_FULL]) else $error("mem-full not flagged");
endmodule

// File: tb/trace_wr_ctrl_test.sv
`timescale 1ns/1ps
module trace_wr_ctrl_test;
  typedef struct packed {
    logic [31:0] s;
    logic [31:0] e;
    logic        lp;
    logic [7:0]  n;
    logic [31:0] fin;
    logic [7:0]  nw;
    logic        full;
    logic        mf;
    logic        emp;
  } vec_t;

  // start, end, loop, words pushed, final pointer, writes, full, memfull raw, fifo empty
  localparam vec_t TV [4] = '{
    '{32'h100, 32'h10C, 1'b1, 8'd6, 32'h108, 8'd6, 1'b0, 1'b1, 1'b1},
    '{32'h040, 32'h050, 1'b1, 8'd3, 32'h04C, 8'd3, 1'b0, 1'b0, 1'b1},
    '{32'h300, 32'h300, 1'b1, 8'd3, 32'h300, 8'd3, 1'b0, 1'b1, 1'b1},
    '{32'h200, 32'h208, 1'b0, 8'd5, 32'h208, 8'd3, 1'b1, 1'b1, 1'b0}
  };

  logic clk = 0, rst_n = 0;
  logic [31:0] cfg_start = 0, cfg_end = 32'hFFFF_FFFF, in_data = 0;
  logic cfg_loop = 1, trig_on = 0, trig_off = 0, rewind = 0, in_valid = 0;
  logic [1:0] irq_en = 0, irq_clr = 0;
  logic in_ready, mem_we, fifo_empty, full_active, irq;
  logic [31:0] mem_addr, mem_wdata, cur_addr;
  logic [1:0] irq_raw;

  int n_chk = 0, n_bad = 0, wr_cnt = 0, q_wr = 0, q_rd = 0;
  logic [31:0] q [256];
  logic [31:0] m_exp = 0;
  logic [31:0] dseq = 32'hA000;
  bit done = 0;

  always #2.5 clk = ~clk;

  trace_wr_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start), .cfg_end(cfg_end),
    .cfg_loop(cfg_loop), .trig_on(trig_on), .trig_off(trig_off), .rewind(rewind),
    .irq_en(irq_en), .irq_clr(irq_clr), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .cur_addr(cur_addr), .fifo_empty(fifo_empty), .full_active(full_active),
    .irq_raw(irq_raw), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // write-port monitor against an independent pointer model (R2, R4)
  always @(negedge clk) begin
    if (rst_n && mem_we) begin
      chk("R2 addr", mem_addr, m_exp);
      chk("R2 data", mem_wdata, q[q_rd[7:0]]);
      q_rd++;
      wr_cnt++;
      if (m_exp == cfg_end) m_exp = cfg_loop ? cfg_start : m_exp;
      else m_exp = m_exp + 4;
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; in_valid = 0; trig_on = 0; trig_off = 0; rewind = 0;
    irq_en = 0; irq_clr = 0;
    repeat (2) @(negedge clk);
    wr_cnt = 0; q_wr = 0; q_rd = 0; m_exp = 0;
    rst_n = 1;
  endtask

  task automatic pulse_rewind();
    @(negedge clk); rewind = 1; m_exp = cfg_start;
    @(negedge clk); rewind = 0;
  endtask

  task automatic pulse_on();
    @(negedge clk); trig_on = 1;
    @(negedge clk); trig_on = 0;
  endtask

  task automatic pulse_off();
    @(negedge clk); trig_off = 1;
    @(negedge clk); trig_off = 0;
  endtask

  task automatic pulse_clr(input logic [1:0] v);
    @(negedge clk); irq_clr = v;
    @(negedge clk); irq_clr = 0;
  endtask

  task automatic push_words(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1; in_data = dseq;
      if (in_ready) begin q[q_wr[7:0]] = dseq; q_wr++; end
      dseq = dseq + 1;
    end
    @(negedge clk); in_valid = 0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    #1;
    // R1 reset state
    chk("R1 cur_addr", cur_addr, 0);
    chk("R1 fifo_empty", {31'd0, fifo_empty}, 1);
    chk("R1 in_ready", {31'd0, in_ready}, 1);
    chk("R1 mem_we", {31'd0, mem_we}, 0);
    chk("R1 full_active", {31'd0, full_active}, 0);
    chk("R1 irq_raw", {30'd0, irq_raw}, 0);
    chk("R1 irq", {31'd0, irq}, 0);

    // table walk: R2, R4, R5, R9
    foreach (TV[k]) begin
      do_reset();
      cfg_start = TV[k].s; cfg_end = TV[k].e; cfg_loop = TV[k].lp;
      pulse_rewind();
      pulse_on();
      push_words(int'(TV[k].n));
      repeat (8) @(negedge clk);
      chk("R4/R5 final pointer", cur_addr, TV[k].fin);
      chk("R2/R5 write count", wr_cnt, {24'd0, TV[k].nw});
      chk("R5 full_active", {31'd0, full_active}, {31'd0, TV[k].full});
      chk("R9 memfull raw", {31'd0, irq_raw[1]}, {31'd0, TV[k].mf});
      chk("R7 fifo_empty", {31'd0, fifo_empty}, {31'd0, TV[k].emp});
    end

    // after the stop-mode entry: R10 enable and clear of memfull
    irq_en = 2'b10; #1;
    chk("R10 irq on memfull", {31'd0, irq}, 1);
    pulse_clr(2'b10); #1;
    chk("R10 clear raw", {30'd0, irq_raw}, 0);
    chk("R10 irq low", {31'd0, irq}, 0);
    chk("R5 still halted", {31'd0, full_active}, 1);
    chk("R5 pointer held", cur_addr, 32'h208);
    pulse_rewind();
    repeat (4) @(negedge clk);
    chk("R3 rewind resumes", cur_addr, 32'h208);
    chk("R5 held words drained", wr_cnt, 5);
    chk("R5 full released", {31'd0, full_active}, 0);

    // overflow with capture off: R7, R8
    do_reset();
    cfg_start = 32'h1000; cfg_end = 32'h1FFC; cfg_loop = 1;
    push_words(5);
    #1;
    chk("R7 in_ready low when full", {31'd0, in_ready}, 0);
    chk("R6 no write while stopped", wr_cnt, 0);
    chk("R8 overflow raw", {30'd0, irq_raw}, 2'b01);
    chk("R10 irq masked", {31'd0, irq}, 0);
    irq_en = 2'b01; #1;
    chk("R10 irq enabled", {31'd0, irq}, 1);
    pulse_clr(2'b01); #1;
    chk("R10 overflow cleared", {31'd0, irq_raw[0]}, 0);
    pulse_rewind();
    pulse_on();
    repeat (8) @(negedge clk);
    chk("R8 dropped word not written", wr_cnt, 4);
    chk("R2 pointer advanced", cur_addr, 32'h1010);
    chk("R7 empty after drain", {31'd0, fifo_empty}, 1);

    // R6 stop then resume
    pulse_off();
    push_words(1);
    repeat (4) @(negedge clk);
    chk("R6 stopped no write", wr_cnt, 4);
    chk("R6 word held", {31'd0, fifo_empty}, 0);
    pulse_on();
    repeat (3) @(negedge clk);
    chk("R6 resumed write", wr_cnt, 5);
    chk("R2 pointer after resume", cur_addr, 32'h1014);

    // R3 rewind mid-run
    pulse_rewind();
    chk("R3 rewind to start", cur_addr, 32'h1000);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule